// File: doc/BRIEF.md
# APB Peripheral Slot Decoder

This block connects a processor's APB target port to as many as twelve peripheral slots. It reads the slot number from one 4-bit field of the address and raises one select line per slot. It then returns the read data, ready and error of that slot to the processor. Each slot is a 256-byte window of 32-bit word registers. The low address bits pass through to the peripherals as a word-register index.

The processor already keeps the address stable and drives the enable phase itself, so the decoder holds no state. Decode and return steering are purely combinational. The clock and reset inputs only time the embedded checks. A select cycle that lands on a window index below the first slot is answered by the decoder itself with an error response, so the processor never waits on an unmapped access.

Top module: `apb_slot_decoder`

## Requirements
- R1: Select output k is high exactly when pSel is high and address bits [11:8] equal 4 + k, for k from 0 to 11.
- R2: When pSel is high and address bits [11:8] are 0, 1, 2 or 3, every select output stays low.
- R3: At most one select output is high in any cycle.
- R4: When pSel is low, all select outputs are low and pRdata, pReady and pSlvErr are all zero.
- R5: When slot k is selected, pRdata equals the 32-bit read word of slot k. That word is bits [32k+31:32k] of slotRdata.
- R6: When slot k is selected, pReady equals slotReady[k].
- R7: When slot k is selected, pSlvErr equals slotErr[k].
- R8: For an unmapped select (R2 case), pReady is 1 and pRdata is 0. pSlvErr equals pEnable: 0 in the setup phase and 1 in the access phase.
- R9: regIdx always equals address bits [7:2], which selects one of 64 word registers in a slot, whatever the value of pSel.
- R10: No output is registered. A change of address between clock edges moves the select, return and index outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pClk | input | 1 | Clock that times the embedded checks |
| pResetN | input | 1 | Active-low reset that disables the checks |
| pSel | input | 1 | Processor APB select |
| pEnable | input | 1 | Processor APB access-phase strobe |
| pAddr | input | 10 | Word address bits [11:2] of the APB window |
| pRdata | output | 32 | Read data returned to the processor |
| pReady | output | 1 | Ready returned to the processor |
| pSlvErr | output | 1 | Error returned to the processor |
| slotSel | output | 12 | One select line per peripheral slot |
| regIdx | output | 6 | Word-register index inside the slot |
| slotRdata | input | 384 | Read words of all slots, 32 bits per slot, slot 0 lowest |
| slotReady | input | 12 | Ready of each slot |
| slotErr | input | 12 | Error of each slot |

## Verification
The hard case is a select whose return values differ from those of a neighbouring slot. A mux that takes the wrong slot, or merges two slots, can still return plausible data. To expose it, every slot gets fresh random read words, ready and error bits on every access, so the slots almost never agree. Directed sweeps cover all sixteen window indices in both phases. This includes the four unmapped indices, where the decoder itself must answer with an error. One further case changes the address between clock edges to show the outputs follow without a clock.

// File: rtl/apb_slot_pkg.sv
package apb_slot_pkg;
  // Strobes from decode control to the return datapath.
  typedef struct packed {
    logic idle;      // no select from the processor
    logic unmapped;  // select lands on an index with no slot
    logic access;    // select together with the access-phase strobe
  } slotStrobe_t;
endpackage

// File: rtl/apb_slot_ctrl.sv
module apb_slot_ctrl
  import apb_slot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SEL_LSB   = 8,
  parameter int SEL_W     = 4,
  parameter int NUM_SLOTS = 12,
  parameter int BASE_IDX  = 4
) (
  input  logic                 pClk,
  input  logic                 pResetN,
  input  logic                 pSel,
  input  logic                 pEnable,
  input  logic [ADDR_W-1:2]    pAddr,
  output logic [NUM_SLOTS-1:0] slotSel,
  output slotStrobe_t          strobe
);
  logic [SEL_W-1:0] winIdx;
  assign winIdx = pAddr[SEL_LSB+SEL_W-1:SEL_LSB];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
    localparam logic [SEL_W-1:0] MATCH = SEL_W'(BASE_IDX + s);
    assign slotSel[s] = pSel && (winIdx == MATCH);
  end

  assign strobe.idle     = !pSel;
  assign strobe.unmapped = pSel && !(|slotSel);
  assign strobe.access   = pSel && pEnable;

  // R3
  onehot_sel_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    $onehot0(slotSel));

  // R4
  idle_sel_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    !pSel |-> (slotSel == '0));

  // R2
  low_idx_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    (pSel && (winIdx < SEL_W'(BASE_IDX))) |-> (slotSel == '0));
endmodule

// File: rtl/apb_slot_mux.sv
module apb_slot_mux
  import apb_slot_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 12
) (
  input  logic                        pClk,
  input  logic                        pResetN,
  input  logic [NUM_SLOTS-1:0]        slotSel,
  input  slotStrobe_t                 strobe,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  input  logic [NUM_SLOTS-1:0]        slotReady,
  input  logic [NUM_SLOTS-1:0]        slotErr,
  output logic [DATA_W-1:0]           pRdata,
  output logic                        pReady,
  output logic                        pSlvErr
);
  logic [DATA_W-1:0] dataAcc;

  always_comb begin
    dataAcc = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      dataAcc = dataAcc | ({DATA_W{slotSel[s]}} & slotRdata[s*DATA_W +: DATA_W]);
    end
  end

  assign pRdata  = dataAcc;
  assign pReady  = (|(slotSel & slotReady)) | strobe.unmapped;
  assign pSlvErr = (|(slotSel & slotErr)) | (strobe.unmapped & strobe.access);

  // R8
  unmapped_resp_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    strobe.unmapped |-> (pReady && (pRdata == '0)));

  // R4
  idle_resp_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    strobe.idle |-> (!pReady && !pSlvErr && (pRdata == '0)));
endmodule

// File: rtl/apb_slot_decoder.sv
module apb_slot_decoder
  import apb_slot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SEL_LSB   = 8,
  parameter int SEL_W     = 4,
  parameter int NUM_SLOTS = 12,
  parameter int BASE_IDX  = 4,
  localparam int REG_W    = SEL_LSB - 2
) (
  input  logic                        pClk,
  input  logic                        pResetN,
  input  logic                        pSel,
  input  logic                        pEnable,
  input  logic [ADDR_W-1:2]           pAddr,
  output logic [DATA_W-1:0]           pRdata,
  output logic                        pReady,
  output logic                        pSlvErr,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic [REG_W-1:0]            regIdx,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  input  logic [NUM_SLOTS-1:0]        slotReady,
  input  logic [NUM_SLOTS-1:0]        slotErr
);
  slotStrobe_t strobe;

  assign regIdx = pAddr[SEL_LSB-1:2];

  apb_slot_ctrl #(
    .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W),
    .NUM_SLOTS(NUM_SLOTS), .BASE_IDX(BASE_IDX)
  ) ctrl_i (
    .pClk(pClk), .pResetN(pResetN), .pSel(pSel), .pEnable(pEnable),
    .pAddr(pAddr), .slotSel(slotSel), .strobe(strobe)
  );

  apb_slot_mux #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) mux_i (
    .pClk(pClk), .pResetN(pResetN), .slotSel(slotSel), .strobe(strobe),
    .slotRdata(slotRdata), .slotReady(slotReady), .slotErr(slotErr),
    .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr)
  );

  // R1
  sel_needs_psel_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    (|slotSel) |-> pSel);
endmodule

// File: tb/apb_slot_decoder_tb_top.sv
module apb_slot_decoder_tb_top;
  localparam int NS = 12;
  localparam int DW = 32;

  logic          pClk = 1'b0;
  logic          pResetN = 1'b0;
  logic          pSel = 1'b0;
  logic          pEnable = 1'b0;
  logic [11:2]   pAddr = '0;
  logic [DW-1:0] pRdata;
  logic          pReady, pSlvErr;
  logic [NS-1:0] slotSel;
  logic [5:0]    regIdx;
  logic [NS*DW-1:0] slotRdata = '0;
  logic [NS-1:0] slotReady = '0;
  logic [NS-1:0] slotErr = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 pClk = ~pClk;

  apb_slot_decoder dut_i (
    .pClk(pClk), .pResetN(pResetN), .pSel(pSel), .pEnable(pEnable),
    .pAddr(pAddr), .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr),
    .slotSel(slotSel), .regIdx(regIdx), .slotRdata(slotRdata),
    .slotReady(slotReady), .slotErr(slotErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] expSel(logic s, logic [11:2] a);
    int idx = int'(a[11:8]);
    if (s && idx >= 4) return NS'(1) << (idx - 4);
    return '0;
  endfunction

  task automatic checkAll();
    logic [NS-1:0] es = expSel(pSel, pAddr);
    int k = int'(pAddr[11:8]) - 4;
    chk("R1 select", 32'(slotSel), 32'(es));
    chk("R9 regIdx", 32'(regIdx), 32'(pAddr[7:2]));
    if (!pSel) begin
      chk("R4 idle rdata", pRdata, '0);
      chk("R4 idle ready", 32'(pReady), 0);
      chk("R4 idle err", 32'(pSlvErr), 0);
    end else if (es == '0) begin
      chk("R2 unmapped select", 32'(slotSel), 0);
      chk("R8 unmapped rdata", pRdata, '0);
      chk("R8 unmapped ready", 32'(pReady), 1);
      chk("R8 unmapped err", 32'(pSlvErr), 32'(pEnable));
    end else begin
      chk("R5 rdata", pRdata, slotRdata[k*DW +: DW]);
      chk("R6 ready", 32'(pReady), 32'(slotReady[k]));
      chk("R7 err", 32'(pSlvErr), 32'(slotErr[k]));
    end
    chk("R3 onehot", 32'($countones(slotSel) <= 1), 1);
  endtask

  task automatic randSlots();
    for (int s = 0; s < NS; s++) slotRdata[s*DW +: DW] = $urandom;
    slotReady = NS'($urandom);
    slotErr   = NS'($urandom);
  endtask

  task automatic apply(input logic s, input logic e, input logic [11:2] a);
    @(negedge pClk);
    pSel = s; pEnable = e; pAddr = a;
    randSlots();
    #1 checkAll();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge pClk);
    #2;
    chk("R4 reset select", 32'(slotSel), 0);
    chk("R4 reset ready", 32'(pReady), 0);
    pResetN = 1'b1;
    // directed sweep of all window indices, both phases
    for (int i = 0; i < 16; i++) begin
      apply(1'b1, 1'b0, {4'(i), 6'(i * 3)});
      apply(1'b1, 1'b1, {4'(i), 6'(63 - i)});
    end
    // idle with a mapped address
    apply(1'b0, 1'b1, {4'd7, 6'd5});
    // R10: address changes between edges, outputs follow without a clock
    apply(1'b1, 1'b1, {4'd4, 6'd0});
    #1 pAddr = {4'd15, 6'd63};
    #1 checkAll();
    chk("R10 live select", 32'(slotSel), 32'(NS'(1) << 11));
    #1 pAddr = {4'd2, 6'd1};
    #1 checkAll();
    chk("R10 live unmapped", 32'(pSlvErr), 1);
    // constrained random
    for (int n = 0; n < 400; n++) begin
      apply(1'(($urandom % 8) != 0), 1'($urandom), 10'($urandom));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule